// File: doc/BRIEF.md
# Relative Mouse Packet Encoder

This block collects relative pointer motion and button activity and turns them into three-byte packets on a byte stream. Signed X and Y deltas are summed into two 16-bit signed accumulators; the Y input is negated as it is summed. Three buttons are tracked as pressed or released, and any button event marks the state as changed. On a sync request, the encoder takes a snapshot of the button state and of the accumulators. It then emits a header byte, an X byte and a Y byte on a valid/ready output.

Each delta byte is the accumulator clamped to -127..+127. Only the part that was sent is taken out of the accumulator, so large motion drains over several packets. A sync request that finds no motion and no button change produces nothing.

Back-pressure rules for the output: `out_valid` stays high and `out_data` stays stable until a cycle with `out_ready` high. A byte transfers on each rising edge where both are high. The encoder never drops or reorders a byte. Inputs are plain one-cycle strobes and are always accepted, including while a packet is waiting on a stalled output.

Top module: `mouse_pkt_enc`

## Requirements
- R1: After reset `out_valid` is 0, both accumulators are zero, all buttons are released and the changed flag is clear.
- R2: Each cycle with `mot_valid` high adds `mot_dx` to the X accumulator and subtracts `mot_dy` from the Y accumulator. The X byte of a packet carries X and the Y byte carries the negated Y input, in two's complement.
- R3: The header byte is 0x87 XOR {5'b0, left, middle, right}. `btn_sel` value 2 is left (bit 2), 1 is middle (bit 1) and 0 is right (bit 0). A pressed button therefore transmits as 0 and a released one as 1.
- R4: An accepted button event sets the pressed bit on `btn_down`=1 and clears it on 0, and it sets the changed flag. Starting a packet clears the flag, so a sync with zero motion sends one packet (X=Y=0x00) and a second sync sends none.
- R5: A sync request while idle, with both accumulators zero and the changed flag clear, starts no packet.
- R6: Each delta byte is its accumulator clamped to -127..+127, and exactly that value is subtracted. An X total of 300 leaves as 0x7F, 0x7F, 0x2E, and a Y input total of +300 leaves as 0x81, 0x81, 0xD2.
- R7: The bytes leave in the order header, X, Y. Each is held stable while `out_ready` is low, and `out_valid` falls after the Y byte transfers.
- R8: A sync request that arrives while a packet is still being sent is ignored.
- R9: On the cycle a packet starts, the snapshot uses the state before that cycle's motion or button event. That cycle's event is applied afterwards and goes into a later packet.
- R10: Each accumulator saturates at ±32767 instead of wrapping.
- R11: A button event with `btn_sel` = 3 is ignored: no bit changes and the changed flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mot_valid | input | 1 | Motion strobe |
| mot_dx | input | 8 | Signed X delta |
| mot_dy | input | 8 | Signed Y delta (negated when summed) |
| btn_valid | input | 1 | Button event strobe |
| btn_sel | input | 2 | Button index: 0 right, 1 middle, 2 left |
| btn_down | input | 1 | 1 = press, 0 = release |
| sync_req | input | 1 | Request to emit a packet if anything is pending |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream ready |

## Verification
A packet start can coincide with new motion and with a button event in the same cycle. The bench raises `sync_req`, `mot_valid` and `btn_valid` together on one clock. It then checks that the packet carries only the earlier state, and that the next sync carries the new delta and the pressed bit. A second collision, a sync arriving while a packet is held by a low `out_ready`, is checked by confirming that exactly one packet appears and that the leftover motion waits for a later sync.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam logic [7:0] HDR_BASE = 8'h87;
  localparam int         BYTE_LIM = 127;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_XB   = 2'd2,
    ST_YB   = 2'd3
  } mpe_state_e;
endpackage

// File: rtl/mpe_axis_acc.sv
module mpe_axis_acc #(
  parameter int IN_W   = 8,
  parameter int ACC_W  = 16,
  parameter bit NEGATE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_delta,
  input  logic            take,
  output logic [7:0]      sent_byte,
  output logic            is_zero
);
  localparam int EXT_W = ACC_W + 2;
  localparam logic signed [EXT_W-1:0] ACC_MAX = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] ACC_MIN = -ACC_MAX;
  localparam logic signed [ACC_W-1:0] LIM_P   = ACC_W'(mpe_pkg::BYTE_LIM);
  localparam logic signed [ACC_W-1:0] LIM_N   = -LIM_P;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] clamp_v;
  logic signed [EXT_W-1:0] d_ext, inc_v, dec_v, sum_v;

  always_comb begin
    if (acc_q > LIM_P)      clamp_v = LIM_P;
    else if (acc_q < LIM_N) clamp_v = LIM_N;
    else                    clamp_v = acc_q;
  end
  assign sent_byte = clamp_v[7:0];
  assign is_zero   = (acc_q == '0);

  generate
    if (NEGATE) begin : g_neg
      assign d_ext = -EXT_W'($signed(in_delta));
    end else begin : g_pos
      assign d_ext = EXT_W'($signed(in_delta));
    end
  endgenerate

  always_comb begin
    inc_v = in_valid ? d_ext : '0;
    dec_v = take ? EXT_W'(clamp_v) : '0;
    sum_v = EXT_W'(acc_q) - dec_v + inc_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               acc_q <= '0;
    else if (sum_v > ACC_MAX) acc_q <= ACC_MAX[ACC_W-1:0];
    else if (sum_v < ACC_MIN) acc_q <= ACC_MIN[ACC_W-1:0];
    else                      acc_q <= sum_v[ACC_W-1:0];
  end

  // R10: the most negative code is never reached
  p_sym_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q != {1'b1, {(ACC_W-1){1'b0}}});
  // R6: a packet start with no new motion moves the accumulator toward zero
  p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_valid && acc_q > LIM_P) |=> (acc_q == $past(acc_q) - LIM_P));
endmodule

// File: rtl/mpe_btn_track.sv
module mpe_btn_track #(
  parameter int NBTN  = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_valid,
  input  logic [SEL_W-1:0] btn_sel,
  input  logic             btn_down,
  input  logic             take,
  output logic [NBTN-1:0]  btn_q,
  output logic             chg_q
);
  logic ev_ok;
  assign ev_ok = btn_valid && (int'(btn_sel) < NBTN);

  generate
    for (genvar i = 0; i < NBTN; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n)                             btn_q[i] <= 1'b0;
        else if (ev_ok && int'(btn_sel) == i)   btn_q[i] <= btn_down;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)     chg_q <= 1'b0;
    else if (ev_ok) chg_q <= 1'b1;
    else if (take)  chg_q <= 1'b0;
  end

  // R4: a packet start without a new event leaves the flag clear
  p_chg_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !btn_valid) |=> !chg_q);
  // R11: an out-of-range index changes no button
  p_bad_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_valid && int'(btn_sel) >= NBTN) |=> $stable(btn_q));
endmodule

// File: rtl/mpe_pkt_fsm.sv
module mpe_pkt_fsm
  import mpe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_req,
  input  logic       pending,
  input  logic [7:0] hdr_in,
  input  logic [7:0] x_in,
  input  logic [7:0] y_in,
  output logic       take,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready
);
  mpe_state_e st_q;
  logic [7:0] hdr_q, x_q, y_q;
  logic       xfer;

  assign take      = (st_q == ST_IDLE) && sync_req && pending;
  assign out_valid = (st_q != ST_IDLE);
  assign xfer      = out_valid && out_ready;

  always_comb begin
    unique case (st_q)
      ST_HDR:  out_data = hdr_q;
      ST_XB:   out_data = x_q;
      ST_YB:   out_data = y_q;
      default: out_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      hdr_q <= '0;
      x_q   <= '0;
      y_q   <= '0;
    end else begin
      if (take) begin
        hdr_q <= hdr_in;
        x_q   <= x_in;
        y_q   <= y_in;
        st_q  <= ST_HDR;
      end else if (xfer) begin
        unique case (st_q)
          ST_HDR:  st_q <= ST_XB;
          ST_XB:   st_q <= ST_YB;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R7: a stalled byte is held
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R7: the stream goes quiet after the Y byte
  p_y_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_YB && out_ready) |=> !out_valid);
  // R3: header keeps its fixed upper pattern
  p_hdr_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HDR) |-> (out_data[7:3] == 5'b10000));
  // R6: a delta byte never holds -128
  p_x_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_XB || st_q == ST_YB) |-> (out_data != 8'h80));
  // R5: nothing pending means no packet
  p_no_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !pending) |=> !out_valid);
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int ACC_W = 16,
  parameter int NBTN  = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mot_valid,
  input  logic [IN_W-1:0]  mot_dx,
  input  logic [IN_W-1:0]  mot_dy,
  input  logic             btn_valid,
  input  logic [SEL_W-1:0] btn_sel,
  input  logic             btn_down,
  input  logic             sync_req,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready
);
  logic            take;
  logic [7:0]      x_byte, y_byte, hdr_byte;
  logic            x_zero, y_zero, chg;
  logic [NBTN-1:0] btns;
  logic            pending;

  mpe_axis_acc #(.IN_W(IN_W), .ACC_W(ACC_W), .NEGATE(1'b0)) u_acc_x (
    .clk(clk), .rst_n(rst_n), .in_valid(mot_valid), .in_delta(mot_dx),
    .take(take), .sent_byte(x_byte), .is_zero(x_zero));

  mpe_axis_acc #(.IN_W(IN_W), .ACC_W(ACC_W), .NEGATE(1'b1)) u_acc_y (
    .clk(clk), .rst_n(rst_n), .in_valid(mot_valid), .in_delta(mot_dy),
    .take(take), .sent_byte(y_byte), .is_zero(y_zero));

  mpe_btn_track #(.NBTN(NBTN), .SEL_W(SEL_W)) u_btn (
    .clk(clk), .rst_n(rst_n), .btn_valid(btn_valid), .btn_sel(btn_sel),
    .btn_down(btn_down), .take(take), .btn_q(btns), .chg_q(chg));

  assign hdr_byte = HDR_BASE ^ {{(8-NBTN){1'b0}}, btns};
  assign pending  = chg || !x_zero || !y_zero;

  mpe_pkt_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .pending(pending),
    .hdr_in(hdr_byte), .x_in(x_byte), .y_in(y_byte), .take(take),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready));

  // R8: no new packet starts while one is in flight
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !take);
endmodule

// File: tb/mouse_pkt_enc_bench.sv
module mouse_pkt_enc_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mot_valid = 1'b0;
  logic [7:0] mot_dx = '0, mot_dy = '0;
  logic       btn_valid = 1'b0;
  logic [1:0] btn_sel = '0;
  logic       btn_down = 1'b0;
  logic       sync_req = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mouse_pkt_enc u_mouse_pkt_enc (
    .clk(clk), .rst_n(rst_n), .mot_valid(mot_valid), .mot_dx(mot_dx),
    .mot_dy(mot_dy), .btn_valid(btn_valid), .btn_sel(btn_sel),
    .btn_down(btn_down), .sync_req(sync_req), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready));

  task automatic check(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic move(input int dx, input int dy);
    @(negedge clk);
    mot_valid = 1'b1; mot_dx = 8'(dx); mot_dy = 8'(dy);
    @(negedge clk);
    mot_valid = 1'b0;
  endtask

  task automatic button(input int sel, input bit down);
    @(negedge clk);
    btn_valid = 1'b1; btn_sel = 2'(sel); btn_down = down;
    @(negedge clk);
    btn_valid = 1'b0;
  endtask

  task automatic do_sync();
    @(negedge clk);
    sync_req = 1'b1;
    @(negedge clk);
    sync_req = 1'b0;
  endtask

  // collects three bytes, out_ready assumed high
  task automatic get_pkt(input string tag, input int h, input int x, input int y);
    int b[3];
    for (int k = 0; k < 3; k++) begin
      int t = 0;
      while (!out_valid && t < 20) begin @(negedge clk); t++; end
      b[k] = out_valid ? int'(out_data) : -1;
      @(negedge clk);
    end
    check({tag, " header"}, b[0], h);
    check({tag, " X"}, b[1], x);
    check({tag, " Y"}, b[2], y);
  endtask

  task automatic expect_none(input string tag);
    int seen = 0;
    for (int k = 0; k < 5; k++) begin
      if (out_valid) seen = 1;
      @(negedge clk);
    end
    check({tag, " no packet"}, seen, 0);
  endtask

  task automatic t_reset();
    check("R1 out_valid after reset", int'(out_valid), 0);
    do_sync();
    expect_none("R5 empty sync");
    expect_none("R1 idle state");
  endtask

  task automatic t_motion();
    move(5, 3);
    do_sync();
    get_pkt("R2 pkt1", 8'h87, 8'h05, 8'hFD);
    move(-10, -20);
    do_sync();
    get_pkt("R2 pkt2", 8'h87, 8'hF6, 8'h14);
  endtask

  task automatic t_buttons();
    button(2, 1'b1);
    do_sync();
    get_pkt("R3 R4 left pressed", 8'h83, 8'h00, 8'h00);
    do_sync();
    expect_none("R4 flag cleared");
    button(0, 1'b1);
    button(2, 1'b0);
    do_sync();
    get_pkt("R3 right pressed", 8'h86, 8'h00, 8'h00);
    button(0, 1'b0);
    do_sync();
    get_pkt("R4 all released", 8'h87, 8'h00, 8'h00);
  endtask

  task automatic t_clamp();
    for (int k = 0; k < 3; k++) move(100, 100);
    do_sync(); get_pkt("R6 part1", 8'h87, 8'h7F, 8'h81);
    do_sync(); get_pkt("R6 part2", 8'h87, 8'h7F, 8'h81);
    do_sync(); get_pkt("R6 rest",  8'h87, 8'h2E, 8'hD2);
    do_sync(); expect_none("R6 drained");
  endtask

  task automatic t_stall();
    int bad = 0;
    move(1, 0);
    out_ready = 1'b0;
    do_sync();
    for (int k = 0; k < 4; k++) begin
      if (!out_valid || out_data != 8'h87) bad++;
      @(negedge clk);
    end
    check("R7 header held under stall", bad, 0);
    out_ready = 1'b1;
    get_pkt("R7 after stall", 8'h87, 8'h01, 8'h00);
    check("R7 valid drops after Y", int'(out_valid), 0);
  endtask

  task automatic t_busy_sync();
    move(2, 0);
    out_ready = 1'b0;
    do_sync();
    move(3, 0);
    do_sync();
    out_ready = 1'b1;
    get_pkt("R8 first", 8'h87, 8'h02, 8'h00);
    expect_none("R8 busy sync ignored");
    do_sync();
    get_pkt("R8 leftover", 8'h87, 8'h03, 8'h00);
  endtask

  task automatic t_collide();
    move(4, 0);
    @(negedge clk);
    sync_req = 1'b1; mot_valid = 1'b1; mot_dx = 8'd7; mot_dy = 8'd0;
    btn_valid = 1'b1; btn_sel = 2'd1; btn_down = 1'b1;
    @(negedge clk);
    sync_req = 1'b0; mot_valid = 1'b0; btn_valid = 1'b0;
    get_pkt("R9 snapshot", 8'h87, 8'h04, 8'h00);
    do_sync();
    get_pkt("R9 deferred", 8'h85, 8'h07, 8'h00);
    button(1, 1'b0);
    do_sync();
    get_pkt("R9 release", 8'h87, 8'h00, 8'h00);
  endtask

  task automatic t_saturate();
    int full = 0, bad = 0, tail;
    @(negedge clk);
    mot_valid = 1'b1; mot_dx = 8'd127; mot_dy = 8'd0;
    repeat (300) @(negedge clk);
    mot_valid = 1'b0;
    // 32767 = 258 * 127 + 1
    tail = -1;
    for (int p = 0; p < 300 && tail < 0; p++) begin
      int xb;
      do_sync();
      if (!out_valid) break;
      @(negedge clk);
      xb = int'(out_data);
      @(negedge clk); @(negedge clk);
      if (xb == 8'h7F) full++;
      else tail = xb;
      if (full > 258) bad++;
    end
    check("R10 full packets at saturation", full, 258);
    check("R10 final remainder", tail, 1);
    check("R10 no extra", bad, 0);
    do_sync();
    expect_none("R10 drained");
  endtask

  task automatic t_bad_sel();
    button(3, 1'b1);
    do_sync();
    expect_none("R11 index 3 ignored");
    do_sync();
    expect_none("R11 still idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_motion();
    t_buttons();
    t_clamp();
    t_stall();
    t_busy_sync();
    t_collide();
    t_saturate();
    t_bad_sel();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule